// File: doc/BRIEF.md
# Sectored Set-Associative Cache Controller

This block sits between a processor port and a slower memory port. Its storage is `SETS` sets of `WAYS` lines. Each line holds `SECTORS` sectors of `SECT_BYTES` bytes. A line is allocated as a whole and carries a single tag. Data moves to and from memory one sector at a time, and each sector keeps its own valid and dirty bits. Each set keeps age-based least-recently-used state, which picks the victim when a new tag needs a line.

Both ports use sector addresses. The lowest log2(`SECTORS`) bits select the sector within a line, the next log2(`SETS`) bits select the set, and the remaining bits form the tag. The processor raises `cpu_req` and holds address, write data and byte enables steady until it sees `cpu_ready`. On a read, the data is valid in that same cycle. The memory side works the same way: `mem_req` stays up, with its address and data steady, until `mem_ack` pulses. On a read, `mem_rdata` is valid with the acknowledge. The controller is blocking. It writes back with write-allocate.

Top module: `sectored_cache`

## Requirements
- R1: A read whose tag matches an allocated line of the set and whose sector is valid raises `cpu_ready` in the cycle of the request, with that sector's data, and issues no memory request.
- R2: A write hit raises `cpu_ready` at once and replaces only the bytes whose `cpu_be` bit is set (bit i covers data bits 8i+7..8i). It marks the sector dirty and issues no memory request.
- R3: A request whose tag matches but whose sector is invalid fetches exactly that one sector into the existing line. Nothing is evicted and nothing is written back.
- R4: On a tag miss, an unallocated way of the set is taken before any allocated way. Otherwise the least recently used way is replaced. Every hit and every fill makes the touched way the most recent.
- R5: Replacing a line writes back each of its dirty sectors, one memory write per sector, with the data last written by the processor. A clean victim causes no memory write.
- R6: A newly allocated line holds only the fetched sector as valid. A later access to any other sector of that line fetches that one sector.
- R7: A write miss first fetches the addressed sector, then merges the write data into it under the byte enables.
- R8: From the detection of a miss until the fill completes, `cpu_ready` stays low. The original request is then serviced as a hit.
- R9: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack`.
- R10: After reset every line is unallocated, no memory request is pending, and the first access misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Sector address |
| cpu_wdata | input | 8*SECT_BYTES | Write data |
| cpu_be | input | SECT_BYTES | Byte enables for writes |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 8*SECT_BYTES | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write-back, 0 = fetch |
| mem_addr | output | AW | Sector address toward memory |
| mem_wdata | output | 8*SECT_BYTES | Write-back data |
| mem_ack | input | 1 | One-cycle memory completion |
| mem_rdata | input | 8*SECT_BYTES | Fetched data, valid with `mem_ack` |

## Verification
The bench goes after several corner cases:
- **Sector miss on a present tag.** A design that treated it as a tag miss would evict the line and emit spurious write-backs.
- **Partial byte-enable writes.** A wrong merge would corrupt neighbouring bytes, which shows up on the read back.
- **Eviction of a partially dirty line, and of a fully clean line.** A wrong design would write back too many or too few sectors, or stale data.
- **A sequence that reorders recency within one set.** A wrong age update would evict the recently used line, giving extra fetches on the next access.
- **Write misses.** These must fetch before merging, or unwritten bytes would read back as garbage.

// File: rtl/sectored_cache.sv
module sectored_cache #(
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int SECTORS    = 4,
  parameter int SECT_BYTES = 4,
  parameter int AW         = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [AW-1:0]           cpu_addr,
  input  logic [8*SECT_BYTES-1:0] cpu_wdata,
  input  logic [SECT_BYTES-1:0]   cpu_be,
  output logic                    cpu_ready,
  output logic [8*SECT_BYTES-1:0] cpu_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [8*SECT_BYTES-1:0] mem_wdata,
  input  logic                    mem_ack,
  input  logic [8*SECT_BYTES-1:0] mem_rdata
);
  localparam int DW   = 8 * SECT_BYTES;
  localparam int SECB = $clog2(SECTORS);
  localparam int IDXB = $clog2(SETS);
  localparam int TW   = AW - SECB - IDXB;
  localparam int SW   = SECB > 0 ? SECB : 1;
  localparam int IW   = IDXB > 0 ? IDXB : 1;
  localparam int WW   = WAYS > 1 ? $clog2(WAYS) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL} state_t;

  logic [DW-1:0]      dat  [SETS][WAYS][SECTORS];
  logic [TW-1:0]      tags [SETS][WAYS];
  logic [WAYS-1:0]    lv   [SETS];
  logic [SECTORS-1:0] vld  [SETS][WAYS];
  logic [SECTORS-1:0] dty  [SETS][WAYS];
  logic [WW-1:0]      age  [SETS][WAYS];

  state_t        st;
  logic [WW-1:0] vway, hway, vic, tw;
  logic [SW-1:0] wsec;
  logic [WAYS-1:0] match;
  logic          mhit, hit, touch;

  wire [IW-1:0] set_i = IW'((cpu_addr >> SECB) & AW'(SETS - 1));
  wire [TW-1:0] tag_i = TW'(cpu_addr >> (SECB + IDXB));
  wire [SW-1:0] sec_i = SW'(cpu_addr & AW'(SECTORS - 1));

  function automatic logic [AW-1:0] mk_addr(input logic [TW-1:0] t, input logic [IW-1:0] s,
                                            input logic [SW-1:0] c);
    return (AW'(t) << (SECB + IDXB)) | (AW'(s) << SECB) | AW'(c);
  endfunction

  always_comb begin
    hway = '0;
    for (int w = 0; w < WAYS; w++) begin
      match[w] = lv[set_i][w] && (tags[set_i][w] == tag_i);
      if (match[w]) hway = WW'(w);
    end
  end

  always_comb begin
    vic = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[set_i][w] == WW'(WAYS - 1)) vic = WW'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!lv[set_i][w]) vic = WW'(w);
  end

  assign mhit      = |match;
  assign hit       = mhit && vld[set_i][hway][sec_i];
  assign cpu_ready = (st == ST_IDLE) && cpu_req && hit;
  assign cpu_rdata = dat[set_i][hway][sec_i];
  assign mem_req   = (st == ST_FILL) || ((st == ST_WB) && dty[set_i][vway][wsec]);
  assign mem_we    = (st == ST_WB);
  assign mem_addr  = (st == ST_WB) ? mk_addr(tags[set_i][vway], set_i, wsec)
                                   : mk_addr(tag_i, set_i, sec_i);
  assign mem_wdata = dat[set_i][vway][wsec];
  assign touch     = cpu_ready || ((st == ST_FILL) && mem_ack);
  assign tw        = (st == ST_IDLE) ? hway : vway;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      vway <= '0;
      wsec <= '0;
      for (int s = 0; s < SETS; s++) begin
        lv[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w] <= '0;
          dty[s][w] <= '0;
          age[s][w] <= WW'(w);
        end
      end
    end else begin
      if (touch)
        for (int w = 0; w < WAYS; w++)
          if (WW'(w) == tw) age[set_i][w] <= '0;
          else if (age[set_i][w] < age[set_i][tw]) age[set_i][w] <= age[set_i][w] + 1'b1;
      case (st)
        ST_IDLE: if (cpu_req) begin
          if (hit) begin
            if (cpu_we) begin
              for (int b = 0; b < SECT_BYTES; b++)
                if (cpu_be[b]) dat[set_i][hway][sec_i][8*b +: 8] <= cpu_wdata[8*b +: 8];
              dty[set_i][hway][sec_i] <= 1'b1;
            end
          end else if (mhit) begin
            vway <= hway;
            st   <= ST_FILL;
          end else begin
            vway <= vic;
            wsec <= '0;
            st   <= ST_WB;
          end
        end
        ST_WB: if (!mem_req || mem_ack) begin
          if (wsec == SW'(SECTORS - 1)) begin
            lv[set_i][vway]   <= 1'b1;
            tags[set_i][vway] <= tag_i;
            vld[set_i][vway]  <= '0;
            dty[set_i][vway]  <= '0;
            st                <= ST_FILL;
          end else begin
            wsec <= wsec + 1'b1;
          end
        end
        ST_FILL: if (mem_ack) begin
          dat[set_i][vway][sec_i] <= mem_rdata;
          vld[set_i][vway][sec_i] <= 1'b1;
          dty[set_i][vway][sec_i] <= 1'b0;
          st                      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_single_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  assert_write_dirty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_we |=> dty[$past(set_i)][$past(hway)][$past(sec_i)]);
  assert_sector_miss_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) && cpu_req && mhit && !hit |=> (st == ST_FILL) && !mem_we);
  assert_fill_then_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FILL) && mem_ack |=> (st == ST_IDLE) && hit);
  assert_no_ready_during_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
endmodule

// File: tb/tb_sectored_cache.sv
`timescale 1ns/1ps
module tb_sectored_cache;
  logic        clk = 0, rst_n = 0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [13:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        cpu_ready, mem_req, mem_we;
  logic [31:0] cpu_rdata, mem_wdata;
  logic [13:0] mem_addr;
  logic        mem_ack = 0;
  logic [31:0] mem_rdata = '0;

  sectored_cache dut (.*);

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, rd_cnt = 0, wr_cnt = 0;
  logic [31:0] refm [int];
  logic [31:0] bmem [int];
  int          lru [4][$];
  logic [3:0]  vm [int];
  logic [3:0]  dm [int];

  function automatic logic [31:0] dflt(int a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [31:0] refv(int a);
    return refm.exists(a) ? refm[a] : dflt(a);
  endfunction
  function automatic int mk(int t, int s, int c);
    return (t << 4) | (s << 2) | c;
  endfunction

  task automatic chk(bit ok, string lbl, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", lbl, what, act, exp);
    end
  endtask

  // memory responder: acknowledges two cycles after a request appears
  initial begin
    int wt = 0;
    logic [13:0] a0 = '0;
    bit seen = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 0; wt = 0; seen = 0;
      end else if (mem_req && rst_n) begin
        if (!seen) begin seen = 1; a0 = mem_addr; end
        else chk(mem_addr == a0, "R9", "memory address held", mem_addr, a0);
        wt++;
        if (wt == 2) begin
          mem_ack = 1;
          if (mem_we) begin
            chk(mem_wdata == refv(int'(mem_addr)), "R5", "write-back data",
                mem_wdata, refv(int'(mem_addr)));
            bmem[int'(mem_addr)] = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata = bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : dflt(int'(mem_addr));
            rd_cnt++;
          end
        end
      end
    end
  end

  task automatic access(string lbl, int a, bit we, logic [31:0] wd, logic [3:0] be);
    int s = (a >> 2) & 3, t = a >> 4, sc = a & 3, key = t * 4 + s, idx = -1;
    int exp_r = 0, exp_w = 0, r0 = rd_cnt, w0 = wr_cnt, waits = 0;
    bit hit = 0;
    logic [31:0] got = '0, expd;
    foreach (lru[s][i]) if (lru[s][i] == t) idx = i;
    if (idx >= 0) begin
      hit = vm[key][sc];
      lru[s].delete(idx);
    end else begin
      if (lru[s].size() == 2) begin
        int vt = lru[s].pop_back();
        exp_w = $countones(dm[vt * 4 + s]);
        vm.delete(vt * 4 + s);
        dm.delete(vt * 4 + s);
      end
      vm[key] = 4'b0;
      dm[key] = 4'b0;
    end
    lru[s].push_front(t);
    exp_r = hit ? 0 : 1;
    vm[key][sc] = 1'b1;
    if (we) dm[key][sc] = 1'b1;
    expd = refv(a);

    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = 14'(a); cpu_wdata = wd; cpu_be = be;
    forever begin
      #1;
      if (cpu_ready) begin got = cpu_rdata; break; end
      @(negedge clk);
      waits++;
      if (waits > 2000) break;
    end
    @(negedge clk);
    cpu_req = 0;

    chk(rd_cnt - r0 == exp_r, lbl, "memory reads", rd_cnt - r0, exp_r);
    chk(wr_cnt - w0 == exp_w, lbl, "memory writes", wr_cnt - w0, exp_w);
    if (hit) chk(waits == 0, "R1", "hit wait cycles", waits, 0);
    else     chk(waits > 0, "R8", "miss stall cycles", waits, 1);
    if (!we) chk(got == expd, lbl, "read data", got, expd);
    else begin
      for (int b = 0; b < 4; b++) if (be[b]) expd[8*b +: 8] = wd[8*b +: 8];
      refm[a] = expd;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    chk(cpu_ready == 0, "R10", "ready in reset", cpu_ready, 0);
    chk(mem_req == 0, "R10", "mem_req in reset", mem_req, 0);
    rst_n = 1;
    @(negedge clk);
    chk(mem_req == 0, "R10", "mem_req after reset", mem_req, 0);
    access("R10 first access", mk(1, 0, 0), 0, 0, 0);
    access("R1 read hit", mk(1, 0, 0), 0, 0, 0);
    access("R3 sector miss", mk(1, 0, 1), 0, 0, 0);
    access("R2 write hit", mk(1, 0, 1), 1, 32'hDEAD_BEEF, 4'hF);
    access("R2 partial write", mk(1, 0, 0), 1, 32'h1122_3344, 4'b0101);
    access("R2 readback", mk(1, 0, 0), 0, 0, 0);
    access("R7 write miss", mk(2, 0, 2), 1, 32'hCAFE_F00D, 4'b0011);
    access("R6 other sector", mk(1, 0, 2), 0, 0, 0);
    access("R4 evict lru", mk(3, 0, 0), 0, 0, 0);
    access("R5 dirty evict", mk(2, 0, 2), 0, 0, 0);
    access("R5 clean evict", mk(4, 0, 0), 0, 0, 0);
    access("R6 sector fetch", mk(4, 0, 3), 0, 0, 0);
    access("R4 hit keeps", mk(2, 0, 2), 0, 0, 0);
    for (int i = 0; i < 400; i++)
      access("R4 mixed", mk($urandom_range(0, 5), $urandom_range(0, 3), $urandom_range(0, 3)),
             1'($urandom_range(0, 1)), $urandom, 4'($urandom_range(1, 15)));
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule